// File: doc/BRIEF.md
# Error Event Counter Register Bank

This block keeps two error tallies for a line framer. One counts framing-bit errors and the other counts CRC errors. The framer supplies a one-cycle increment strobe for each counter. A host processor reads the counts through an 8-bit register port that has one cycle of read latency. Each count is split into a low byte and a high byte at neighbouring addresses. The host reads the low byte first. That read captures the upper bits, so the pair of bytes stays coherent even if the counter keeps counting.

Each counter has its own overflow-interrupt enable, and that enable also decides what happens when the counter is full. With the enable set, the counter wraps to zero. With it clear, the counter sticks at its maximum. Every overflow raises a sticky status flag. The interrupt line is high whenever a flag is set and its enable is set.

The block runs in one of two modes:
- **Direct mode:** a read of a high byte clears that whole counter.
- **Latched mode:** a once-per-second strobe moves the live counts into snapshot registers and restarts the live counters. Host reads then return the snapshot and clear nothing.

Top module: `errbank_top`

## Requirements
- R1: After a synchronous reset, both counts, both holding registers, both snapshots, the status flags, `rd_data` and `irq` are zero.
- R2: Each increment strobe adds one to its counter.
  - The framing count is 12 bits: bits 7:0 at address 0, bits 11:8 in bits 3:0 of address 1.
  - The CRC count is 10 bits: bits 7:0 at address 2, bits 9:8 in bits 1:0 of address 3.
  - The unused upper bits of a high byte read as zero.
- R3: With the counter's enable set (`ovf_ie[0]` framing, `ovf_ie[1]` CRC), an increment at the maximum value wraps the count to zero.
- R4: With the counter's enable clear, an increment at the maximum value leaves the count at the maximum.
- R5: An increment at the maximum value, in either overflow policy, sets that counter's sticky flag in the status register at address 4 (bit 0 framing, bit 1 CRC, other bits zero).
  - A read of address 4 returns the flags and then clears them.
  - A flag set in the same cycle as that read survives.
- R6: `irq` is high exactly when some status flag is set and its enable is set, as seen one cycle after each clock edge.
- R7: A low-byte read copies the upper bits of that count into a holding register. A high-byte read returns the held bits, not the present count.
- R8: In direct mode (`latch_mode` low), a high-byte read clears the whole count. An increment in that same cycle leaves the count at 1.
- R9: In latched mode, `sec_tick` copies each live count into its snapshot and restarts the live count at 0, or at 1 when an increment coincides.
  - Reads return snapshot values and clear nothing.
- R10: In direct mode, `sec_tick` has no effect on any count.
- R11: `rd_data` changes only in the cycle after a read strobe and holds its value otherwise. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_err_inc | input | 1 | Framing-bit error strobe |
| crc_err_inc | input | 1 | CRC error strobe |
| sec_tick | input | 1 | One-second strobe |
| latch_mode | input | 1 | 1 = latched snapshot mode, 0 = direct clear-on-read mode |
| ovf_ie | input | 2 | Per-counter overflow interrupt enable; also selects wrap (1) or saturate (0) |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host register address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The assertions check the following on every cycle:
- wrap and saturate behaviour at the maximum count;
- the clear-on-read restart value;
- the snapshot capture;
- flag stickiness;
- that `irq` is never high without a set flag;
- the zero upper bits of the CRC high byte.

Some properties only show up across whole access sequences, so only the bench's scenarios can demonstrate them:
- the coherence of a low/high byte pair across intervening increments;
- a thousand-event walk to saturation or wrap;
- the insensitivity of direct mode to the second strobe;
- the non-destructive reads in latched mode.

The bench compares `rd_data` and `irq` with a behavioural model on every clock.

// File: rtl/errbank_pkg.sv
package errbank_pkg;
  localparam int RD_ADDR_W = 3;
  localparam logic [RD_ADDR_W-1:0] A_FRM_LO = 3'd0;
  localparam logic [RD_ADDR_W-1:0] A_FRM_HI = 3'd1;
  localparam logic [RD_ADDR_W-1:0] A_CRC_LO = 3'd2;
  localparam logic [RD_ADDR_W-1:0] A_CRC_HI = 3'd3;
  localparam logic [RD_ADDR_W-1:0] A_STAT   = 3'd4;
  localparam int N_CNT = 2;
endpackage

// File: rtl/errbank_counter.sv
module errbank_counter #(
  parameter int W    = 12,
  parameter int LO_W = 8,
  parameter int HW   = W - LO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          clr,
  input  logic          tick,
  input  logic          latch_mode,
  input  logic          wrap_en,
  input  logic          cap_hi,
  output logic [W-1:0]  vis,
  output logic [HW-1:0] hold,
  output logic          ovf
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] live;
  logic [W-1:0] snap;
  logic         tick_eff;
  logic         at_max;
  logic [W-1:0] inc_w;

  always_comb begin
    tick_eff = tick & latch_mode;
    at_max   = (live == MAXV);
    inc_w    = {{(W-1){1'b0}}, inc};
    vis      = latch_mode ? snap : live;
    ovf      = inc & at_max & ~tick_eff & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      snap <= '0;
      hold <= '0;
    end else begin
      if (tick_eff) begin
        snap <= live;
        live <= inc_w;
      end else if (clr) begin
        live <= inc_w;
      end else if (inc) begin
        if (!at_max)     live <= live + 1'b1;
        else if (wrap_en) live <= '0;
      end
      if (cap_hi) hold <= vis[W-1:LO_W];
    end
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && at_max && wrap_en && !clr && !tick_eff) |=> (live == '0));
  p_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && at_max && !wrap_en && !clr && !tick_eff) |=> (live == MAXV));
  p_clr_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick_eff) |=> (live == {{(W-1){1'b0}}, $past(inc)}));
  p_snap_r9: assert property (@(posedge clk) disable iff (rst)
    tick_eff |=> (snap == $past(live)));
endmodule

// File: rtl/errbank_flags.sv
module errbank_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] nxt;

  always_comb nxt = (flags & ~{N{clr}}) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= |(nxt & ie);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr) |=> flags[i]);
  end

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|flags));
endmodule

// File: rtl/errbank_top.sv
module errbank_top
  import errbank_pkg::*;
#(
  parameter int FRM_W  = 12,
  parameter int CRC_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_err_inc,
  input  logic                 crc_err_inc,
  input  logic                 sec_tick,
  input  logic                 latch_mode,
  input  logic [N_CNT-1:0]     ovf_ie,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq
);
  localparam int FRM_HW = FRM_W - DATA_W;
  localparam int CRC_HW = CRC_W - DATA_W;

  logic [FRM_W-1:0]  frm_vis;
  logic [CRC_W-1:0]  crc_vis;
  logic [FRM_HW-1:0] frm_hold;
  logic [CRC_HW-1:0] crc_hold;
  logic              frm_ovf, crc_ovf;
  logic [N_CNT-1:0]  flags;
  logic              frm_clr, crc_clr, frm_cap, crc_cap, stat_rd;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    frm_cap = rd_en && (rd_addr == A_FRM_LO);
    crc_cap = rd_en && (rd_addr == A_CRC_LO);
    frm_clr = rd_en && (rd_addr == A_FRM_HI) && !latch_mode;
    crc_clr = rd_en && (rd_addr == A_CRC_HI) && !latch_mode;
    stat_rd = rd_en && (rd_addr == A_STAT);
  end

  errbank_counter #(.W(FRM_W), .LO_W(DATA_W)) u_frm (
    .clk(clk), .rst(rst), .inc(frm_err_inc), .clr(frm_clr), .tick(sec_tick),
    .latch_mode(latch_mode), .wrap_en(ovf_ie[0]), .cap_hi(frm_cap),
    .vis(frm_vis), .hold(frm_hold), .ovf(frm_ovf));

  errbank_counter #(.W(CRC_W), .LO_W(DATA_W)) u_crc (
    .clk(clk), .rst(rst), .inc(crc_err_inc), .clr(crc_clr), .tick(sec_tick),
    .latch_mode(latch_mode), .wrap_en(ovf_ie[1]), .cap_hi(crc_cap),
    .vis(crc_vis), .hold(crc_hold), .ovf(crc_ovf));

  errbank_flags #(.N(N_CNT)) u_flags (
    .clk(clk), .rst(rst), .set({crc_ovf, frm_ovf}), .clr(stat_rd),
    .ie(ovf_ie), .flags(flags), .irq(irq));

  always_comb begin
    case (rd_addr)
      A_FRM_LO: rd_mux = frm_vis[DATA_W-1:0];
      A_FRM_HI: rd_mux = {{(DATA_W-FRM_HW){1'b0}}, frm_hold};
      A_CRC_LO: rd_mux = crc_vis[DATA_W-1:0];
      A_CRC_HI: rd_mux = {{(DATA_W-CRC_HW){1'b0}}, crc_hold};
      A_STAT:   rd_mux = {{(DATA_W-N_CNT){1'b0}}, flags};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_crc_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_CRC_HI) |=> (rd_data[DATA_W-1:CRC_HW] == '0));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/errbank_top_tb.sv
module errbank_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_err_inc = 0, crc_err_inc = 0, sec_tick = 0, latch_mode = 0, rd_en = 0;
  logic [1:0] ovf_ie = 2'b00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int fl, cl, fs, cs, fh, ch, flg, rd_m, irq_m;

  always #2 clk = ~clk;

  errbank_top u_dut (
    .clk(clk), .rst(rst), .frm_err_inc(frm_err_inc), .crc_err_inc(crc_err_inc),
    .sec_tick(sec_tick), .latch_mode(latch_mode), .ovf_ie(ovf_ie), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit fi, input bit ci, input bit tk, input bit rd, input int a);
    int vf, vc, nf;
    bit tke, clf, clc, of, oc;
    vf  = latch_mode ? fs : fl;
    vc  = latch_mode ? cs : cl;
    tke = tk && latch_mode;
    clf = rd && a == 1 && !latch_mode;
    clc = rd && a == 3 && !latch_mode;
    if (rd) begin
      case (a)
        0: rd_m = vf % 256;
        1: rd_m = fh;
        2: rd_m = vc % 256;
        3: rd_m = ch;
        4: rd_m = flg;
        default: rd_m = 0;
      endcase
      if (a == 0) fh = vf / 256;
      if (a == 2) ch = vc / 256;
    end
    of = fi && fl == 4095 && !tke && !clf;
    oc = ci && cl == 1023 && !tke && !clc;
    if (tke) begin fs = fl; fl = fi; cs = cl; cl = ci; end
    else begin
      if (clf) fl = fi;
      else if (fi) fl = (fl < 4095) ? fl + 1 : (ovf_ie[0] ? 0 : 4095);
      if (clc) cl = ci;
      else if (ci) cl = (cl < 1023) ? cl + 1 : (ovf_ie[1] ? 0 : 1023);
    end
    nf  = ((rd && a == 4) ? 0 : flg) | (of ? 1 : 0) | (oc ? 2 : 0);
    flg = nf;
    irq_m = ((nf & ovf_ie) != 0) ? 1 : 0;
  endtask

  task automatic step(input bit fi, input bit ci, input bit tk, input bit rd, input int a,
                      input string tag);
    frm_err_inc = fi; crc_err_inc = ci; sec_tick = tk; rd_en = rd; rd_addr = a[2:0];
    @(posedge clk);
    model_edge(fi, ci, tk, rd, a);
    @(negedge clk);
    check({tag, " rd_data"}, int'(rd_data), rd_m);
    check({tag, " irq"}, int'(irq), irq_m);
    frm_err_inc = 0; crc_err_inc = 0; sec_tick = 0; rd_en = 0;
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 0, 1, a, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fl = 0; cl = 0; fs = 0; cs = 0; fh = 0; ch = 0; flg = 0; rd_m = 0; irq_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 5; a++) rd(a, "R1");

    // R2 basic counting and byte layout
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 300; i++) step(1, 1, 0, 0, 0, "R2");
    rd(0, "R2"); rd(1, "R2"); rd(2, "R2"); rd(3, "R2");
    check("R2 crc hi direct", int'(rd_data), 303 / 256);

    // R11 unused addresses, hold without strobe
    rd(5, "R11"); rd(7, "R11");
    check("R11 unused addr", int'(rd_data), 0);
    step(1, 1, 0, 0, 0, "R11");

    // R10 tick ignored in direct mode
    rd(1, "R8 clear"); rd(3, "R8 clear");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 0, "R10");
    rd(0, "R10");
    check("R10 count unchanged", int'(rd_data), 7);

    // R8 clear with coincident increment
    rd(0, "R8");
    step(1, 0, 0, 1, 1, "R8");
    rd(0, "R8");
    check("R8 restart at 1", int'(rd_data), 1);
    rd(1, "R8 clear");

    // R4 saturate framing counter
    ovf_ie = 2'b00;
    for (int i = 0; i < 4100; i++) step(1, 0, 0, 0, 0, "R4");
    rd(0, "R4");
    check("R4 lo", int'(rd_data), 255);
    rd(1, "R4");
    check("R4 hi", int'(rd_data), 15);
    rd(4, "R5");
    check("R5 flag bit0", int'(rd_data), 1);
    check("R6 irq masked", int'(irq), 0);
    rd(4, "R5 cleared");
    check("R5 flag cleared", int'(rd_data), 0);

    // R3 wrap CRC counter, irq
    ovf_ie = 2'b10;
    rd(3, "R3 clear");
    for (int i = 0; i < 1026; i++) step(0, 1, 0, 0, 0, "R3");
    check("R6 irq set", int'(irq), 1);
    rd(2, "R3");
    check("R3 wrapped", int'(rd_data), 2);
    rd(4, "R5");
    check("R5 flag bit1", int'(rd_data), 2);
    check("R6 irq cleared", int'(irq), 0);

    // R7 coherent byte pair
    rd(3, "R7 clear");
    for (int i = 0; i < 250; i++) step(0, 1, 0, 0, 0, "R7");
    rd(2, "R7");
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, "R7");
    rd(3, "R7");
    check("R7 held hi", int'(rd_data), 0);

    // R9 latched mode
    latch_mode = 1;
    for (int i = 0; i < 9; i++) step(1, 1, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, "R9 tick");
    rd(0, "R9"); rd(1, "R9"); rd(0, "R9");
    check("R9 snapshot kept", int'(rd_data), 9);
    step(0, 0, 1, 0, 0, "R9 tick2");
    rd(0, "R9");
    check("R9 restart 1", int'(rd_data), 1);
    rd(2, "R9");
    check("R9 crc restart 0", int'(rd_data), 0);

    repeat (2) step(0, 0, 0, 0, 0, "idle");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule